// File: doc/BRIEF.md
# Four-Mode SPI Master Byte Engine

This block is a single-target SPI master that moves one byte at a time in full duplex. A write on the data port starts a transfer. One register holds the outgoing byte. As each bit leaves on the serial output, the bit taken in from the serial input enters that same register at the other end. When the transfer ends, the received byte appears on the read port and stays there until the next transfer completes.

The serial clock is always produced here, by dividing the system clock with a programmable value. Polarity and phase inputs select one of the four usual clocking modes. The select line is active low and covers each transfer. A hold input keeps the line asserted between bytes, so a multi-byte burst can run under one select. Clock mode, phase and divider are captured when a transfer starts.

Top module: `spi_master_core`

## Requirements
- R1: While reset is held, ss_n is 1, busy and done are 0, mosi is 0, rd_data is 0 and sclk is 0.
- R2: A wr_en pulse while busy is 0 starts a transfer: busy is 1 from the next cycle. A wr_en pulse while busy is 1 is ignored, and wr_data has no effect on mosi or rd_data.
- R3: When idle, sclk equals cfg_cpol as sampled on the previous clock. During a transfer, sclk toggles every cfg_div+1 clock cycles, 16 times in all, and so ends at its idle level.
- R4: Data on mosi is sent most significant bit first. With cfg_cpha=0, bit 7 is on mosi from the cycle after the write, and mosi changes on the 2nd, 4th, … sclk edge. With cfg_cpha=1, bit 7 appears on the 1st edge and mosi changes on odd-numbered edges. Between edges mosi is stable, and after the transfer it keeps its last value.
- R5: miso is sampled on the rising sclk edge when cfg_cpol equals cfg_cpha, and on the falling edge otherwise. This is the 1st, 3rd, … edge when cfg_cpha=0 and the 2nd, 4th, … edge when cfg_cpha=1. The first sampled bit is bit 7 of rd_data.
- R6: done is a one-cycle pulse in the cycle after the 16th sclk edge. In that same cycle busy returns to 0 and rd_data takes the received byte. rd_data changes at no other time.
- R7: ss_n goes low in the cycle after a transfer starts and stays low while busy. After the last edge it returns to 1 unless hold_sel is 1. While the block is idle, ss_n returns to 1 at the first clock where hold_sel is 0.
- R8: cfg_cpol, cfg_cpha and cfg_div are captured when a transfer starts. Changing them during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cpol | input | 1 | Idle level of sclk |
| cfg_cpha | input | 1 | 0: sample on leading edges; 1: sample on trailing edges |
| cfg_div | input | DIV_W | Half-period of sclk, minus one, in clock cycles |
| hold_sel | input | 1 | Keep ss_n low after a transfer ends |
| wr_en | input | 1 | Write strobe; starts a transfer when idle |
| wr_data | input | DATA_W | Byte to send |
| rd_data | output | DATA_W | Last received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| sclk | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |
| ss_n | output | 1 | Target select, active low |

## Verification
On every cycle, the assertions check properties that hold regardless of mode or data. The select line is low whenever busy is 1. done lasts one cycle and only ends a transfer. busy rises only after a write. The idle clock level follows the polarity input. mosi holds still between sclk edges. rd_data moves only with done. What only the bench scenarios can show is the bit order and sampling edge in each of the four modes, the exact edge spacing for several divider values, and the received byte. The bench also shows that a write during a transfer is ignored, that configuration changes mid-transfer have no effect, and how the select line behaves across a held burst.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

   // Clocking mode as captured at the start of a transfer
   typedef struct packed {
      logic cpol;
      logic cpha;
   } spi_mode_t;

   localparam spi_mode_t SPI_MODE_RST = '{cpol: 1'b0, cpha: 1'b0};

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clear,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("spi_tick_gen: DIV_W must be at least 1");
      end
   endgenerate

   assign tick = run && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear || !run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              cpha,
   input  logic              tick,
   input  logic              samp,
   input  logic              first,
   input  logic              last,
   input  logic              miso,
   output logic              mosi,
   output logic [DATA_W-1:0] word_next
);

   logic [DATA_W-1:0] sh_q;
   logic              rx_bit_q;

   // On the last edge the final received bit enters the low end
   assign word_next = {sh_q[DATA_W-2:0], (cpha ? miso : rx_bit_q)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '0;
         rx_bit_q <= 1'b0;
         mosi     <= 1'b0;
      end else if (load) begin
         sh_q <= load_data;
         if (!cpha) begin
            mosi <= load_data[DATA_W-1];
         end
      end else if (tick) begin
         if (samp) begin
            rx_bit_q <= miso;
         end
         if (last) begin
            sh_q <= word_next;
         end else if (!samp) begin
            if (first) begin
               mosi <= sh_q[DATA_W-1];
            end else begin
               mosi <= sh_q[DATA_W-2];
               sh_q <= {sh_q[DATA_W-2:0], rx_bit_q};
            end
         end
      end
   end

endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
   import spi_master_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              hold_sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              ss_n
);

   localparam int EDGES  = 2 * DATA_W;
   localparam int EDGE_W = $clog2(EDGES);
   localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_master_core: DATA_W must be at least 2");
      end
   endgenerate

   spi_mode_t         mode_q;
   logic [DIV_W-1:0]  div_q;
   logic [EDGE_W-1:0] edge_q;
   logic              busy_q;
   logic              done_q;
   logic              ss_n_q;
   logic [DATA_W-1:0] rd_q;

   logic              start;
   logic              tick;
   logic              samp;
   logic              first;
   logic              last;
   logic              finish;
   logic              cpha_eff;
   logic [DATA_W-1:0] word_next;

   assign start    = wr_en && !busy_q;
   assign samp     = (edge_q[0] == mode_q.cpha);
   assign first    = (edge_q == '0);
   assign last     = (edge_q == LAST_EDGE);
   assign finish   = tick && last;
   assign cpha_eff = start ? cfg_cpha : mode_q.cpha;

   spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy_q),
      .clear (start),
      .div   (div_q),
      .tick  (tick)
   );

   spi_shift_reg #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .load_data (wr_data),
      .cpha      (cpha_eff),
      .tick      (tick),
      .samp      (samp),
      .first     (first),
      .last      (last),
      .miso      (miso),
      .mosi      (mosi),
      .word_next (word_next)
   );

   // Configuration follows the inputs while idle and freezes during a transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= SPI_MODE_RST;
         div_q  <= '0;
      end else if (!busy_q) begin
         mode_q <= '{cpol: cfg_cpol, cpha: cfg_cpha};
         div_q  <= cfg_div;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         edge_q <= '0;
         done_q <= 1'b0;
         rd_q   <= '0;
         ss_n_q <= 1'b1;
      end else begin
         done_q <= finish;
         if (start) begin
            busy_q <= 1'b1;
            edge_q <= '0;
            ss_n_q <= 1'b0;
         end else begin
            if (finish) begin
               busy_q <= 1'b0;
               edge_q <= '0;
               rd_q   <= word_next;
            end else if (tick) begin
               edge_q <= edge_q + 1'b1;
            end
            if ((!busy_q || finish) && !hold_sel) begin
               ss_n_q <= 1'b1;
            end
         end
      end
   end

   assign sclk    = mode_q.cpol ^ edge_q[0];
   assign busy    = busy_q;
   assign done    = done_q;
   assign rd_data = rd_q;
   assign ss_n    = ss_n_q;

endmodule

// File: rtl/spi_master_core_chk.sv
module spi_master_core_chk #(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_cpol,
   input logic              wr_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              busy,
   input logic              done,
   input logic              sclk,
   input logic              mosi,
   input logic              ss_n
);

   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R7
   sel_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ss_n);

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && done) |-> (!busy && $past(busy)));

   // R2
   start_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(busy)) |-> $past(wr_en));

   // R3
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !busy && !$past(busy)) |-> (sclk == $past(cfg_cpol)));

   // R4
   mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && busy && $past(busy) && $stable(sclk)) |-> $stable(mosi));

   // R6
   rd_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !done) |-> $stable(rd_data));

endmodule

bind spi_master_core spi_master_core_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_cpol (cfg_cpol),
   .wr_en    (wr_en),
   .rd_data  (rd_data),
   .busy     (busy),
   .done     (done),
   .sclk     (sclk),
   .mosi     (mosi),
   .ss_n     (ss_n)
);

// File: tb/spi_master_core_bench.sv
`timescale 1ns/1ps
module spi_master_core_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_cpol = 1'b0;
   logic       cfg_cpha = 1'b0;
   logic [7:0] cfg_div = 8'd0;
   logic       hold_sel = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       busy, done, sclk, mosi, ss_n;
   logic       miso = 1'b1;
   logic [7:0] slave_byte = 8'h00;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   // Reference model state
   bit       m_act = 0;
   int       m_t = 0, m_h = 1, m_n = 0;
   bit [7:0] m_d = 0, m_s = 0, m_rd = 0;
   bit       m_cpol = 0, m_cpha = 0, m_ss = 1, m_done = 0, m_mosi = 0;

   always #5 clk = ~clk;

   spi_master_core u_spi_master_core (
      .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_div(cfg_div), .hold_sel(hold_sel), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .busy(busy), .done(done), .sclk(sclk), .mosi(mosi),
      .miso(miso), .ss_n(ss_n)
   );

   task automatic check(input string tag, input int got, input int exp);
      tests++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   // Model step: one call per rising clock edge
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_act = 0; m_cpol = 0; m_ss = 1; m_done = 0; m_rd = 0; m_mosi = 0; m_n = 0;
      end else begin
         m_done = 0;
         if (!m_act) begin
            m_cpol = cfg_cpol;
            if (wr_en) begin
               m_act = 1; m_t = 0; m_n = 0; m_d = wr_data; m_s = slave_byte;
               m_cpha = cfg_cpha; m_h = int'(cfg_div) + 1; m_ss = 0;
               if (!m_cpha) m_mosi = m_d[7];
            end else if (!hold_sel) begin
               m_ss = 1;
            end
         end else begin
            m_t++;
            if (m_t == m_h) begin
               m_t = 0;
               m_n++;
               if (m_n == 16) begin
                  m_act = 0; m_done = 1; m_rd = m_s;
                  if (!hold_sel) m_ss = 1;
               end else if (!m_cpha) begin
                  m_mosi = m_d[7 - m_n/2];
               end else begin
                  m_mosi = m_d[7 - (m_n-1)/2];
               end
            end
         end
      end
   end

   // Compare every cycle, then present the target's next bit
   always @(negedge clk) begin
      check("R2 busy", busy, m_act);
      check("R3 sclk", sclk, m_cpol ^ (m_act ? m_n[0] : 1'b0));
      check("R4 mosi", mosi, m_mosi);
      check("R5 rd_data", rd_data, m_rd);
      check("R6 done", done, m_done);
      check("R7 ss_n", ss_n, m_ss);
      if (m_act && !(m_cpha && m_n == 0)) begin
         miso = m_cpha ? m_s[7 - (m_n-1)/2] : m_s[7 - m_n/2];
      end else begin
         miso = 1'b1;
      end
   end

   task automatic xfer(input logic [7:0] d, input logic [7:0] s, input logic pol,
                       input logic pha, input logic [7:0] dv, input logic hold);
      @(negedge clk);
      cfg_cpol = pol; cfg_cpha = pha; cfg_div = dv; hold_sel = hold;
      wr_data = d; slave_byte = s; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      while (busy) @(negedge clk);
      check("R6 byte received", rd_data, s);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 ss_n", ss_n, 1);
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 mosi", mosi, 0);
      check("R1 rd_data", rd_data, 0);
      check("R1 sclk", sclk, 0);
      rst_n = 1'b1;

      // R4 R5: each of the four modes, several dividers
      xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 8'd0, 1'b0);
      xfer(8'h96, 8'hC3, 1'b0, 1'b1, 8'd1, 1'b0);
      xfer(8'h5A, 8'h81, 1'b1, 1'b0, 8'd2, 1'b0);
      xfer(8'hF0, 8'h0F, 1'b1, 1'b1, 8'd3, 1'b0);

      // R7: burst under one select
      xfer(8'h12, 8'hED, 1'b0, 1'b0, 8'd1, 1'b1);
      xfer(8'h34, 8'hCB, 1'b0, 1'b0, 8'd1, 1'b1);
      check("R7 held between bytes", ss_n, 0);
      xfer(8'h56, 8'hA9, 1'b1, 1'b1, 8'd0, 1'b1);
      hold_sel = 1'b0;
      repeat (2) @(negedge clk);
      check("R7 released when idle", ss_n, 1);

      // R2 R8: write and configuration changes during a transfer are ignored
      @(negedge clk);
      cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_div = 8'd2; hold_sel = 1'b0;
      wr_data = 8'hC6; slave_byte = 8'h6C; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (5) @(negedge clk);
      wr_data = 8'hFF; wr_en = 1'b1;
      cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_div = 8'd0;
      @(negedge clk);
      wr_en = 1'b0;
      while (busy) @(negedge clk);
      check("R8 byte under frozen config", rd_data, 8'h6C);
      repeat (2) @(negedge clk);
      check("R3 idle level follows new polarity", sclk, 1);

      xfer(8'h00, 8'hFF, 1'b0, 1'b1, 8'd4, 1'b0);
      xfer(8'hFF, 8'h00, 1'b1, 1'b0, 8'd1, 1'b0);
      repeat (4) @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   always @(posedge clk) begin
      if (cycles > 150000) begin
         tests++;
         fails++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule